// File: doc/BRIEF.md
# Edge-Set Event Status Register

This block keeps a sticky record of which power-management events have raised a request. Each of its sixteen (by default) status bits has its own event input and its own enable. A bit becomes 1 when its event goes from inactive to active while the bit is enabled. It stays 1 until software writes a 0 into that position. A single request output is high whenever any status bit is 1, so an interrupt handler is called while work is pending.

The bits are triggered by edges, not by levels. If an event is still held high when software clears its bit, the bit does not come back, so one activation gives exactly one indication. If the hardware sets a bit in the same cycle that software clears it, the bit ends up 1, and the handler does not lose the new event. Software writes a full data word and enables it one byte at a time. A data bit of 0 clears the matching status bit and a data bit of 1 leaves it alone, so handlers can acknowledge single bits without a read-modify-write. Event inputs are asynchronous and pass through a synchronizer of configurable depth before edge detection.

Top module: `pm_edge_status`

## Requirements
- R1: While reset is asserted, every status bit reads 0 and the request output is 0.
- R2: A 0-to-1 transition on an enabled event input sets its status bit, and the bit is visible SYNC_STAGES+1 clock edges after the input rises (3 edges with the default of 2). An event that is high for only one clock cycle is still recorded.
- R3: A rising event whose enable is 0 when the edge is detected leaves its status bit unchanged. Enabling the bit later while the event is still held high does not set it either.
- R4: On a write, each status bit in an enabled byte whose data bit is 0 becomes 0 one edge later. Each bit whose data bit is 1 keeps its value.
- R5: Status bits in a byte whose byte enable is 0 keep their value, whatever the write data holds. Byte enable bit b covers status bits [8b+7:8b].
- R6: A status bit that software clears while its event is still held high stays 0 until the event falls and then rises again.
- R7: When a hardware set and a software clear of the same bit happen in the same cycle, the bit ends up 1.
- R8: A status bit that has been set stays 1 after its event falls, until software clears it.
- R9: The request output is 1 exactly when at least one status bit is 1, in the same cycle as the status value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Asynchronous event inputs, active high |
| evt_en_i | input | NUM_SRC | Per-bit event enables |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_be_i | input | NUM_SRC/BYTE_W | Byte enables for the write |
| wr_data_i | input | NUM_SRC | Write data: 0 clears a bit, 1 leaves it unchanged |
| status_o | output | NUM_SRC | Current status bits |
| irq_o | output | 1 | Request output, OR of all status bits |

## Verification
The assertions check four things on every cycle: the reset value, that no bit rises without a detected enabled edge, that a detected set always wins over a clear, and that a cleared bit drops while an uncleared bit holds. They compare the status word against the write ports and the internal set vector. Only the bench scenarios can show the exact latency from an event input to its status bit, that a held event does not re-arm after a clear, and that an enable raised during a held event creates no edge. Those depend on the input history over many cycles. The bench also lines up a write with a detected edge to exercise the collision rule from the ports.

// File: rtl/pm_stat_pkg.sv
package pm_stat_pkg;
   parameter int unsigned PM_SRC_DEF  = 16;
   parameter int unsigned PM_BYTE_DEF = 8;
   parameter int unsigned PM_SYNC_DEF = 2;
   parameter int unsigned PM_SYNC_MAX = 4;

   function automatic int unsigned pm_num_bytes(int unsigned n, int unsigned b);
      return (n + b - 1) / b;
   endfunction
endpackage

// File: rtl/pm_evt_edge.sv
module pm_evt_edge #(
   parameter int unsigned N      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] synced;
   logic [N-1:0] prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = evt_i;
      end else begin : g_sync
         logic [N-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
            end else begin
               chain_q[0] <= evt_i;
               for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
            end
         end
         assign synced = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;
   end

   assign rise_o = synced & ~prev_q;
endmodule

// File: rtl/pm_wr_decode.sv
module pm_wr_decode #(
   parameter int unsigned N      = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NB     = 2
) (
   input  logic          wr_en_i,
   input  logic [NB-1:0] wr_be_i,
   input  logic [N-1:0]  wr_data_i,
   output logic [N-1:0]  clr_o
);
   generate
      for (genvar b = 0; b < NB; b++) begin : g_byte
         assign clr_o[b*BYTE_W +: BYTE_W] =
            {BYTE_W{wr_en_i & wr_be_i[b]}} & ~wr_data_i[b*BYTE_W +: BYTE_W];
      end
   endgenerate
endmodule

// File: rtl/pm_stat_reg.sv
module pm_stat_reg #(
   parameter int unsigned N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stat_o[i] <= 1'b0;
            else if (set_i[i]) stat_o[i] <= 1'b1;
            else if (clr_i[i]) stat_o[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/pm_edge_status.sv
module pm_edge_status
   import pm_stat_pkg::*;
#(
   parameter int unsigned NUM_SRC     = PM_SRC_DEF,
   parameter int unsigned BYTE_W      = PM_BYTE_DEF,
   parameter int unsigned SYNC_STAGES = PM_SYNC_DEF,
   localparam int unsigned NUM_BYTES  = pm_num_bytes(NUM_SRC, BYTE_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   evt_i,
   input  logic [NUM_SRC-1:0]   evt_en_i,
   input  logic                 wr_en_i,
   input  logic [NUM_BYTES-1:0] wr_be_i,
   input  logic [NUM_SRC-1:0]   wr_data_i,
   output logic [NUM_SRC-1:0]   status_o,
   output logic                 irq_o
);
   generate
      if (NUM_SRC == 0 || BYTE_W == 0) begin : g_bad_width
         $error("pm_edge_status: NUM_SRC and BYTE_W must be nonzero");
      end
      if (NUM_SRC % BYTE_W != 0) begin : g_bad_bytes
         $error("pm_edge_status: NUM_SRC must be a multiple of BYTE_W");
      end
      if (SYNC_STAGES > PM_SYNC_MAX) begin : g_bad_sync
         $error("pm_edge_status: SYNC_STAGES exceeds the supported depth");
      end
   endgenerate

   logic [NUM_SRC-1:0] rise_vec;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] clr_vec;

   pm_evt_edge #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .rise_o (rise_vec)
   );

   assign set_vec = rise_vec & evt_en_i;

   pm_wr_decode #(.N(NUM_SRC), .BYTE_W(BYTE_W), .NB(NUM_BYTES)) u_dec (
      .wr_en_i   (wr_en_i),
      .wr_be_i   (wr_be_i),
      .wr_data_i (wr_data_i),
      .clr_o     (clr_vec)
   );

   pm_stat_reg #(.N(NUM_SRC)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .stat_o (status_o)
   );

   assign irq_o = |status_o;
endmodule

// File: rtl/pm_edge_status_chk.sv
module pm_edge_status_chk #(
   parameter int unsigned NUM_SRC   = 16,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned NUM_BYTES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en_i,
   input logic [NUM_BYTES-1:0] wr_be_i,
   input logic [NUM_SRC-1:0]   wr_data_i,
   input logic [NUM_SRC-1:0]   set_vec,
   input logic [NUM_SRC-1:0]   status_o,
   input logic                 irq_o
);
   logic [NUM_SRC-1:0] wmask;
   logic [NUM_SRC-1:0] want_clr;

   generate
      for (genvar b = 0; b < NUM_BYTES; b++) begin : g_mask
         assign wmask[b*BYTE_W +: BYTE_W] = {BYTE_W{wr_be_i[b]}};
      end
   endgenerate

   assign want_clr = wr_en_i ? (wmask & ~wr_data_i) : '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_ZERO: assert (status_o == '0 && !irq_o); // R1
      end
   end

   AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o & ~$past(status_o)) & ~$past(set_vec)) == '0); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(set_vec) & ~status_o) == '0); // R7

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(want_clr & ~set_vec) & status_o) == '0); // R4

   AST_UNCLEARED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_o & ~want_clr) & ~status_o) == '0); // R8
endmodule

bind pm_edge_status pm_edge_status_chk #(
   .NUM_SRC   (NUM_SRC),
   .BYTE_W    (BYTE_W),
   .NUM_BYTES (NUM_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en_i   (wr_en_i),
   .wr_be_i   (wr_be_i),
   .wr_data_i (wr_data_i),
   .set_vec   (set_vec),
   .status_o  (status_o),
   .irq_o     (irq_o)
);

// File: tb/test_pm_edge_status.sv
`timescale 1ns/1ps
module test_pm_edge_status;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] evt;
   logic [15:0] evt_en;
   logic        wr_en;
   logic [1:0]  wr_be;
   logic [15:0] wr_data;
   logic [15:0] status;
   logic        irq;

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 0;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   pm_edge_status i_pm_edge_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt),
      .evt_en_i  (evt_en),
      .wr_en_i   (wr_en),
      .wr_be_i   (wr_be),
      .wr_data_i (wr_data),
      .status_o  (status),
      .irq_o     (irq)
   );

   task automatic step(int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      #1;
   endtask

   task automatic expect_now(string tag, logic [15:0] v);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic do_write(logic [1:0] be, logic [15:0] d);
      wr_en = 1'b1; wr_be = be; wr_data = d;
      step(1);
      wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'hFFFF;
   endtask

   // monitor: compares at the falling edge, away from the active edge
   always @(negedge clk) begin
      if (tag_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         compared++;
         if (status !== e || irq !== (|e)) begin
            mismatched++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     t, status, irq, e, |e);
         end
      end
   end

   initial begin
      rst_n = 1'b0; evt = '0; evt_en = 16'hFFDF; // bit 5 disabled
      wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'hFFFF;
      step(3);
      expect_now("R1 reset value", 16'h0000);
      step(1);
      rst_n = 1'b1;
      step(1);

      // R2: enabled rise, visible after 3 edges
      evt[3] = 1'b1;
      step(2);
      expect_now("R2 not yet visible after 2 edges", 16'h0000);
      step(1);
      expect_now("R2 R9 set after 3 edges", 16'h0008);

      // R3: disabled event rises
      evt[5] = 1'b1;
      step(4);
      expect_now("R3 disabled rise ignored", 16'h0008);

      // R8: event drops, bit stays
      evt[3] = 1'b0;
      step(4);
      expect_now("R8 bit held after event drops", 16'h0008);

      // R4: clear bit 3 with a 0, others written 1
      do_write(2'b01, 16'hFFF7);
      expect_now("R4 R9 write 0 clears", 16'h0000);

      // R3: enable bit 5 while its event is held high
      evt_en[5] = 1'b1;
      step(4);
      expect_now("R3 late enable on held event", 16'h0000);

      // R5 / R6: set bits 3 and 12, clear only the low byte
      evt[3] = 1'b1; evt[12] = 1'b1;
      step(3);
      expect_now("R2 two sources set", 16'h1008);
      do_write(2'b01, 16'h0000);
      expect_now("R5 unenabled byte kept", 16'h1000);
      step(4);
      expect_now("R6 held event no re-set", 16'h1000);

      // R7: clear of bit 9 lands on its set edge
      evt[9] = 1'b1;
      step(2);
      do_write(2'b10, 16'hFDFF);
      expect_now("R7 set wins over clear", 16'h1200);

      // R6: clear everything with events still high
      do_write(2'b11, 16'h0000);
      expect_now("R4 clear all", 16'h0000);
      step(4);
      expect_now("R6 held events stay clear", 16'h0000);

      // R2 / R8: one-cycle pulses on bits 0 and 15
      evt = '0;
      step(3);
      evt[0] = 1'b1; evt[15] = 1'b1;
      step(1);
      evt[0] = 1'b0; evt[15] = 1'b0;
      step(2);
      expect_now("R2 R8 short pulses recorded", 16'h8001);

      // R4: writing 1s changes nothing
      do_write(2'b11, 16'hFFFF);
      expect_now("R4 write 1 no effect", 16'h8001);

      step(3);
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!finished) begin
         finished = 1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule